// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

This block gathers single-cycle event pulses from up to four groups of eight interrupt sources. Each source has a sticky status bit and a mask bit. A set mask bit switches off event capture for its source. It does not only hide the output. All unmasked pending bits are combined onto one interrupt line whose active level can be programmed. The same condition drives an ON-request flag and a flag that permits sleep.

A host reaches the status, mask and control registers through a simple synchronous bus with one-cycle read latency. Status registers sit at offsets 0 to 3, mask registers at offsets 4 to 7, and the control register at offset 8. One control bit selects how status is cleared, for every register at once: either a read clears the register, or the host writes ones to the bits it wants cleared. Another control bit decides whether the interrupt line may assert while the device reports the sleep state.

Top module: `irq_agg_top`

## Requirements
- R1: After reset the outputs are at their idle levels: `irq_o`=1 (inactive for active-low polarity), `on_req_o`=0 and `sleep_ok_o`=1. All status bits, mask bits and control bits are 0.
- R2: A pulse on `evt_i[g*8+b]` while mask bit b of group g is 0 sets status bit b of group g at that clock edge. The status register of group g is read at offset g.
- R3: While mask bit b of group g is 1, an event on that source is not recorded. It cannot make the interrupt line assert.
- R4: A status bit that was set before its mask bit was written to 1 stays set until it is cleared. While masked it can still be cleared, but events do not set it again.
- R5: The interrupt is active when any status bit with a 0 mask bit is set. `irq_o` follows the status one clock later. Control bit 0 chooses the level: 0 gives an active-low line and 1 gives an active-high line.
- R6: With control bit 1 = 0 (clear on read), a read of status offset g returns that register and clears all of its bits at the same edge.
- R7: With control bit 1 = 1 (clear on write), a write to status offset g clears the bits written as 1 and keeps the bits written as 0. Reads in this mode do not clear.
- R8: If an event arrives in the same cycle that its status bit is being cleared, the bit ends up set.
- R9: With control bit 2 = 0 and `sleep_i` = 1, the interrupt line and `on_req_o` stay inactive. With control bit 2 = 1, the line may assert during sleep. `sleep_ok_o` ignores this gating.
- R10: `on_req_o` is 1 exactly when the interrupt line is active. `sleep_ok_o` is 0 while any unmasked status bit is pending. Both flags are registered like `irq_o`.
- R11: `bus_rdata_o` is loaded one edge after a read. Mask registers are at offsets 4 to 7 and the control register (bits 2:0) is at offset 8. Other offsets read as 0. A write to a status offset in clear-on-read mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event pulses, group g bit b at index g*8+b |
| sleep_i | input | 1 | Device is in the sleep state |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt line, programmable polarity |
| on_req_o | output | 1 | ON request, high while the interrupt is active |
| sleep_ok_o | output | 1 | High when no unmasked status bit is pending |

## Verification
The assertions check, on every cycle and for every bit, the following rules:
- a masked clear bit never becomes set;
- an unmasked event always lands in its status bit, even when a clear arrives in the same cycle;
- a read in clear-on-read mode empties the register;
- a zero written in clear-on-write mode preserves its bit;
- an ON request always withdraws sleep permission;
- sleep gating holds the request low.

Other behaviour can only be shown by the bench's scenarios and its per-cycle reference model:
- the polarity of the line;
- the latched bit that survives masking;
- the ignored status write in clear-on-read mode;
- the read-back of mask and control registers;
- the one-cycle output latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // control register layout: bit0 polarity, bit1 clear mode, bit2 sleep allow
  typedef struct packed {
    logic allow_sleep;
    logic clr_on_wr;
    logic pol_high;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/irq_group.sv
module irq_group
  import irq_agg_pkg::*;
#(
  parameter int GW      = 8,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int ST_ADDR = 0,
  parameter int MK_ADDR = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] evt_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cow_i,
  output logic [GW-1:0] stat_o,
  output logic [GW-1:0] mask_o,
  output logic          pend_o
);
  logic [GW-1:0] stat_q, mask_q, set_v, clr_v;
  logic st_hit, mk_hit;

  assign st_hit = (addr_i == AW'(ST_ADDR));
  assign mk_hit = (addr_i == AW'(MK_ADDR));

  always_comb begin
    set_v = evt_i & ~mask_q;
    clr_v = '0;
    if (st_hit) begin
      if (rd_i && !cow_i) clr_v = '1;
      if (wr_i && cow_i)  clr_v = wdata_i[GW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= set_v | (stat_q & ~clr_v);
      if (wr_i && mk_hit) mask_q <= wdata_i[GW-1:0];
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

  a_r3_masked_no_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(mask_q & ~stat_q)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_q & $past(evt_i & ~mask_q)) == '0));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_i && st_hit && !cow_i) |=> ((stat_q & ~$past(evt_i & ~mask_q)) == '0));

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_i && st_hit && cow_i) |=> (($past(stat_q & ~wdata_i[GW-1:0]) & ~stat_q) == '0));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_agg_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int CTRL_ADDR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_i && addr_i == AW'(CTRL_ADDR)) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_out.sv
module irq_out
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pend_any_i,
  input  logic  sleep_i,
  input  ctrl_t ctrl_i,
  output logic  irq_o,
  output logic  on_req_o,
  output logic  sleep_ok_o
);
  logic act;

  assign act = pend_any_i && (!sleep_i || ctrl_i.allow_sleep);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b1;
      on_req_o   <= 1'b0;
      sleep_ok_o <= 1'b1;
    end else begin
      irq_o      <= ctrl_i.pol_high ? act : !act;
      on_req_o   <= act;
      sleep_ok_o <= !pend_any_i;
    end
  end

  a_r10_onreq_blocks_sleep: assert property (@(posedge clk) disable iff (rst)
    on_req_o |-> !sleep_ok_o);

  a_r9_sleep_gate: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !ctrl_i.allow_sleep) |=> !on_req_o);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int GW     = 8,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GROUPS*GW-1:0] evt_i,
  input  logic                 sleep_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  output logic                 irq_o,
  output logic                 on_req_o,
  output logic                 sleep_ok_o
);
  localparam int CTRL_ADDR = 2 * GROUPS;

  ctrl_t           ctrl;
  logic [GW-1:0]   stat_a [GROUPS];
  logic [GW-1:0]   mask_a [GROUPS];
  logic [GROUPS-1:0] pend_v;
  logic [DW-1:0]   rd_mux;

  irq_ctrl_reg #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .ctrl_o(ctrl)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    irq_group #(.GW(GW), .AW(AW), .DW(DW), .ST_ADDR(g), .MK_ADDR(GROUPS + g)) u_grp (
      .clk(clk), .rst(rst), .evt_i(evt_i[g*GW +: GW]),
      .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .cow_i(ctrl.clr_on_wr),
      .stat_o(stat_a[g]), .mask_o(mask_a[g]), .pend_o(pend_v[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (bus_addr_i == AW'(g))          rd_mux = DW'(stat_a[g]);
      if (bus_addr_i == AW'(GROUPS + g)) rd_mux = DW'(mask_a[g]);
    end
    if (bus_addr_i == AW'(CTRL_ADDR)) rd_mux = DW'(ctrl);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

  irq_out u_out (
    .clk(clk), .rst(rst), .pend_any_i(|pend_v), .sleep_i(sleep_i),
    .ctrl_i(ctrl), .irq_o(irq_o), .on_req_o(on_req_o), .sleep_ok_o(sleep_ok_o)
  );
endmodule

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;
  logic        clk = 0, rst = 1;
  logic [31:0] evt = '0;
  logic        slp = 0, wr = 0, rd = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq, onr, sok;

  int checks = 0, failures = 0;

  irq_agg_top dut (
    .clk(clk), .rst(rst), .evt_i(evt), .sleep_i(slp), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .on_req_o(onr), .sleep_ok_o(sok)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_stat[4], m_mask[4], m_ctrl, m_rdata;
  bit m_irq = 1, m_on = 0, m_ok = 1;

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 4; g++) begin m_stat[g] = 0; m_mask[g] = 0; end
      m_ctrl = 0; m_rdata = 0; m_irq = 1; m_on = 0; m_ok = 1;
    end else begin
      bit pend, act;
      int nstat[4];
      pend = 0;
      for (int g = 0; g < 4; g++) if ((m_stat[g] & ~m_mask[g] & 255) != 0) pend = 1;
      act = pend && (!slp || ((m_ctrl >> 2) & 1) == 1);
      m_on = act; m_ok = !pend;
      m_irq = (m_ctrl & 1) ? act : !act;
      if (rd) begin
        if (addr < 4) m_rdata = m_stat[addr];
        else if (addr < 8) m_rdata = m_mask[addr-4];
        else if (addr == 8) m_rdata = m_ctrl;
        else m_rdata = 0;
      end
      for (int g = 0; g < 4; g++) begin
        int s, c;
        s = (evt >> (8*g)) & 255 & ~m_mask[g];
        c = 0;
        if (addr == g && rd && ((m_ctrl >> 1) & 1) == 0) c = 255;
        if (addr == g && wr && ((m_ctrl >> 1) & 1) == 1) c = wdata;
        nstat[g] = (s | (m_stat[g] & ~c)) & 255;
      end
      for (int g = 0; g < 4; g++) begin
        m_stat[g] = nstat[g];
        if (wr && addr == 4 + g) m_mask[g] = wdata;
      end
      if (wr && addr == 8) m_ctrl = wdata & 7;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R5 irq_o model", irq, m_irq);
    chk("R10 on_req_o model", onr, m_on);
    chk("R10 sleep_ok_o model", sok, m_ok);
    chk("R11 rdata model", rdata, m_rdata);
  end

  task automatic cyc(input logic [31:0] e, input logic r, input logic w,
                     input logic [3:0] a, input logic [7:0] d);
    evt = e; rd = r; wr = w; addr = a; wdata = d;
    @(negedge clk);
    evt = '0; rd = 0; wr = 0;
  endtask

  task automatic idle(); cyc('0, 0, 0, 0, 0); endtask
  task automatic wreg(input logic [3:0] a, input logic [7:0] d); cyc('0, 0, 1, a, d); endtask
  task automatic rreg(input logic [3:0] a, input int exp, input string tag);
    cyc('0, 1, 0, a, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq_o idle", irq, 1); chk("R1 on_req_o", onr, 0); chk("R1 sleep_ok_o", sok, 1);
    rreg(4, 0, "R1 mask reset"); rreg(8, 0, "R1 ctrl reset");
    // R2 / R5 / R10: event sets status, line goes low
    cyc(32'h8, 0, 0, 0, 0); idle();
    chk("R5 irq active low", irq, 0); chk("R10 on_req", onr, 1); chk("R10 sleep_ok", sok, 0);
    // R6 clear on read
    rreg(0, 8'h08, "R2 status g0"); idle();
    chk("R6 irq released", irq, 1);
    rreg(0, 0, "R6 cleared by read");
    // R3 masked source
    wreg(5, 8'h01); cyc(32'h100, 0, 0, 0, 0); idle(); idle();
    chk("R3 irq idle", irq, 1);
    rreg(1, 0, "R3 not recorded");
    // R4 latched survives mask
    cyc(32'h20 << 16, 0, 0, 0, 0); wreg(6, 8'h20); cyc(32'h20 << 16, 0, 0, 0, 0); idle();
    chk("R4 masked latched not pending", irq, 1);
    rreg(2, 8'h20, "R4 latched kept");
    cyc(32'h20 << 16, 0, 0, 0, 0);
    rreg(2, 0, "R4 no recapture");
    // R5 polarity high
    wreg(8, 8'h01); cyc(32'h80 << 24, 0, 0, 0, 0); idle();
    chk("R5 irq active high", irq, 1);
    rreg(3, 8'h80, "R2 status g3"); idle();
    chk("R5 irq high idle", irq, 0);
    // R7 clear on write
    wreg(8, 8'h03); cyc(32'h3, 0, 0, 0, 0);
    rreg(0, 3, "R7 read 1"); rreg(0, 3, "R7 read does not clear");
    wreg(0, 8'h01); rreg(0, 2, "R7 write one clears only that bit");
    // R8 set beats clear
    cyc(32'h10, 0, 1, 0, 8'h12); rreg(0, 8'h10, "R8 set priority");
    wreg(0, 8'h10); rreg(0, 0, "R7 all cleared");
    // R9 sleep gating
    wreg(8, 8'h01); slp = 1; cyc(32'h80 << 8, 0, 0, 0, 0); idle();
    chk("R9 irq gated", irq, 0); chk("R9 on_req gated", onr, 0); chk("R9 sleep_ok low", sok, 0);
    wreg(8, 8'h05); idle();
    chk("R9 irq allowed in sleep", irq, 1);
    slp = 0; rreg(1, 8'h80, "R9 status kept"); idle();
    // R11 map
    rreg(8, 5, "R11 ctrl read"); rreg(5, 1, "R11 mask read"); rreg(9, 0, "R11 unused offset");
    wreg(8, 8'h01); cyc(32'h4, 0, 0, 0, 0); wreg(0, 8'h04);
    rreg(0, 8'h04, "R11 status write ignored in read-clear mode");
    repeat (3) idle();
    summary();
  end
endmodule